// File: doc/BRIEF.md
# Reference Clock Guard

This block supervises two reference clocks from a free-running, trusted monitor clock. Each reference is brought into the monitor domain through a synchronizer. Its rising edges feed an activity tracker, and the tracker declares the reference lost after a long enough silence. It declares the reference good again only after a sustained run of activity.

A selection state machine uses the health of both references to pick the one that drives the downstream PLL. Input 0 is the primary and input 1 is the backup. When neither reference can be used, the machine enters holdover so the PLL keeps its last setting.

Every loss event latches a per-input failure flag, and the unmasked flags are combined into one interrupt line. A revert mode controls what happens when a reference comes back:

- With revert on, recovery clears the flag and moves selection back to the primary.
- With revert off, the flag stays set until it is cleared by a write-one pulse, and selection stays on the backup.

A reference whose enable bit is low is ignored: its tracker is held idle, it never raises a flag, and it is never selected.

Top module: `refclk_guard`

## Requirements
- R1: After reset, `sel_o` is 0 (primary), `holdover_o` is 0, `fail_sts_o` is 00 and `irq_o` is 0.
- R2: An enabled input is declared lost when it shows no rising edge for 64 consecutive monitor cycles. Rising edges no more than 62 cycles apart keep it healthy.
- R3: A loss of input i sets `fail_sts_o[i]` (bit 0 is the primary, bit 1 is the backup), and the bit is held.
- R4: `irq_o` is high exactly when some `fail_sts_o[i]` is set while `fail_mask_i[i]` is 0. A mask bit of 1 hides input i from the interrupt.
- R5: A lost input counts as healthy again only after 256 consecutive monitor cycles during which no 64-cycle silence occurs.
- R6: When the primary is lost and the backup is healthy, `sel_o` becomes 1 and `holdover_o` stays 0.
- R7: When no enabled input is healthy, `holdover_o` is 1. Holdover ends as soon as an enabled input is healthy, with the primary taken when both are healthy.
- R8: With `revert_en_i` at 0, a recovered primary does not clear `fail_sts_o[0]` and selection stays on the backup. A one-cycle pulse on `fail_clr_i[i]` clears `fail_sts_o[i]`.
- R9: With `revert_en_i` at 1, recovery of input i clears `fail_sts_o[i]`, and recovery of the primary returns `sel_o` to 0.
- R10: An input whose `ref_en_i` bit is 0 never sets its status bit and is never eligible for selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Monitor clock (stable local clock) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 2 | Reference clocks, bit 0 primary, bit 1 backup |
| ref_en_i | input | 2 | Per-input enable; 0 switches that monitor off |
| revert_en_i | input | 1 | 1 = recovery clears status and restores the primary |
| fail_mask_i | input | 2 | Per-input interrupt mask, 1 = masked |
| fail_clr_i | input | 2 | Write-one-to-clear pulse for the status bits |
| sel_o | output | 1 | Selected input: 0 primary, 1 backup |
| holdover_o | output | 1 | High while no usable input exists |
| fail_sts_o | output | 2 | Latched per-input failure flags |
| irq_o | output | 1 | OR of the unmasked failure flags |

## Verification
The references are driven as periodic clocks of chosen half-periods, as stopped clocks, and as clocks that restart after a stop.

- A 62-cycle period against a 70-cycle period shows that the loss threshold sits between the two.
- Sampling a restarted input once before and once after the 256-cycle window shows that recovery is not premature.
- Running the same loss and recovery with revert on and with revert off separates sticky flags from self-clearing ones.
- Stopping both clocks, restarting one, and restarting both at once shows the holdover entry and the exit preference.
- Disabling an input and then killing its clock shows that it neither flags a failure nor counts as a candidate for selection.

// File: rtl/refclk_guard_pkg.sv
`timescale 1ns/1ps
package refclk_guard_pkg;
   typedef enum logic [1:0] {
      SEL_MAIN   = 2'd0,
      SEL_BACKUP = 2'd1,
      SEL_HOLD   = 2'd2
   } sel_state_e;
endpackage

// File: rtl/refclk_guard_edge.sv
`timescale 1ns/1ps
// Synchronizes one reference clock into the monitor domain and flags rising edges.
module refclk_guard_edge #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic rise_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("refclk_guard_edge: STAGES must be at least 2");
      end
   endgenerate

   // Stages 0..STAGES-1 synchronize; the last stage is the edge-detect delay.
   logic [STAGES:0] pipe_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= {pipe_q[STAGES-1:0], async_i};
   end

   assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/refclk_guard_activity.sv
`timescale 1ns/1ps
// Tracks silence and sustained activity of one synchronized reference.
module refclk_guard_activity #(
   parameter int LOSS_CYC  = 64,
   parameter int RECOV_CYC = 256
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic rise_i,
   output logic ok_o,
   output logic lost_p_o,
   output logic back_p_o
);
   generate
      if (LOSS_CYC < 2)  begin : g_bad_loss
         $error("refclk_guard_activity: LOSS_CYC must be at least 2");
      end
      if (RECOV_CYC < 2) begin : g_bad_recov
         $error("refclk_guard_activity: RECOV_CYC must be at least 2");
      end
   endgenerate

   localparam int IW = $clog2(LOSS_CYC + 1);
   localparam int RW = $clog2(RECOV_CYC);
   localparam logic [IW-1:0] LOSS_V     = IW'(LOSS_CYC);
   localparam logic [RW-1:0] RECOV_LAST = RW'(RECOV_CYC - 1);

   logic [IW-1:0] idle_q, idle_d;
   logic [RW-1:0] run_q, run_d;
   logic          alive_q, alive_d, lost_d, back_d;

   always_comb begin
      idle_d  = idle_q;
      run_d   = run_q;
      alive_d = alive_q;
      lost_d  = 1'b0;
      back_d  = 1'b0;
      if (!en_i) begin
         idle_d  = '0;
         run_d   = '0;
         alive_d = 1'b1;
      end else begin
         if (rise_i)                idle_d = '0;
         else if (idle_q != LOSS_V) idle_d = idle_q + 1'b1;
         if (alive_q) begin
            if (idle_d == LOSS_V) begin
               alive_d = 1'b0;
               lost_d  = 1'b1;
            end
         end else if (idle_d == LOSS_V) begin
            run_d = '0;
         end else if (run_q == RECOV_LAST) begin
            run_d   = '0;
            alive_d = 1'b1;
            back_d  = 1'b1;
         end else begin
            run_d = run_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         idle_q   <= '0;
         run_q    <= '0;
         alive_q  <= 1'b1;
         lost_p_o <= 1'b0;
         back_p_o <= 1'b0;
      end else begin
         idle_q   <= idle_d;
         run_q    <= run_d;
         alive_q  <= alive_d;
         lost_p_o <= lost_d;
         back_p_o <= back_d;
      end
   end

   assign ok_o = en_i & alive_q;
endmodule

// File: rtl/refclk_guard_select.sv
`timescale 1ns/1ps
// Primary / backup / holdover selection.
module refclk_guard_select
   import refclk_guard_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] ok_i,
   input  logic       revert_i,
   output logic       sel_o,
   output logic       hold_o
);
   sel_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      case (st_q)
         SEL_MAIN:
            if (!ok_i[0]) st_d = ok_i[1] ? SEL_BACKUP : SEL_HOLD;
         SEL_BACKUP:
            if (ok_i[0] && (revert_i || !ok_i[1])) st_d = SEL_MAIN;
            else if (!ok_i[1])                     st_d = SEL_HOLD;
         default:
            if (ok_i[0])      st_d = SEL_MAIN;
            else if (ok_i[1]) st_d = SEL_BACKUP;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= SEL_MAIN;
         sel_o <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_d == SEL_MAIN)        sel_o <= 1'b0;
         else if (st_d == SEL_BACKUP) sel_o <= 1'b1;
      end
   end

   assign hold_o = (st_q == SEL_HOLD);
endmodule

// File: rtl/refclk_guard.sv
`timescale 1ns/1ps
module refclk_guard #(
   parameter int N_REF       = 2,
   parameter int SYNC_STAGES = 2,
   parameter int LOSS_CYC    = 64,
   parameter int RECOV_CYC   = 256
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_REF-1:0] ref_clk_i,
   input  logic [N_REF-1:0] ref_en_i,
   input  logic             revert_en_i,
   input  logic [N_REF-1:0] fail_mask_i,
   input  logic [N_REF-1:0] fail_clr_i,
   output logic             sel_o,
   output logic             holdover_o,
   output logic [N_REF-1:0] fail_sts_o,
   output logic             irq_o
);
   generate
      if (N_REF != 2) begin : g_bad_nref
         $error("refclk_guard: selection supports exactly two references");
      end
   endgenerate

   logic [N_REF-1:0] rise, ref_ok, lost_p, back_p;

   for (genvar g = 0; g < N_REF; g++) begin : g_ch
      refclk_guard_edge #(.STAGES(SYNC_STAGES)) i_edge (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .async_i (ref_clk_i[g]),
         .rise_o  (rise[g])
      );
      refclk_guard_activity #(.LOSS_CYC(LOSS_CYC), .RECOV_CYC(RECOV_CYC)) i_act (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .en_i     (ref_en_i[g]),
         .rise_i   (rise[g]),
         .ok_o     (ref_ok[g]),
         .lost_p_o (lost_p[g]),
         .back_p_o (back_p[g])
      );
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                                   fail_sts_o[g] <= 1'b0;
         else if (lost_p[g])                            fail_sts_o[g] <= 1'b1;
         else if (fail_clr_i[g] || (revert_en_i && back_p[g])) fail_sts_o[g] <= 1'b0;
      end
   end

   refclk_guard_select i_sel (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ok_i     (ref_ok),
      .revert_i (revert_en_i),
      .sel_o    (sel_o),
      .hold_o   (holdover_o)
   );

   assign irq_o = |(fail_sts_o & ~fail_mask_i);
endmodule

// File: rtl/refclk_guard_chk.sv
`timescale 1ns/1ps
module refclk_guard_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [1:0] ok,
   input logic [1:0] lost_p,
   input logic [1:0] ref_en_i,
   input logic       revert_en_i,
   input logic [1:0] fail_clr_i,
   input logic [1:0] fail_sts_o,
   input logic       sel_o,
   input logic       holdover_o
);
   p_holdover_exit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ok != 2'b00) |=> !holdover_o);

   p_stay_backup_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!revert_en_i && sel_o && !holdover_o && ok[1]) |=> (sel_o && !holdover_o));

   for (genvar i = 0; i < 2; i++) begin : g_bit
      p_fail_sets_status_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         lost_p[i] |=> fail_sts_o[i]);

      p_sticky_norevert_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (fail_sts_o[i] && !revert_en_i && !fail_clr_i[i]) |=> fail_sts_o[i]);

      p_disabled_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $past(!ref_en_i[i]) |-> !lost_p[i]);
   end
endmodule

bind refclk_guard refclk_guard_chk i_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .ok          (ref_ok),
   .lost_p      (lost_p),
   .ref_en_i    (ref_en_i),
   .revert_en_i (revert_en_i),
   .fail_clr_i  (fail_clr_i),
   .fail_sts_o  (fail_sts_o),
   .sel_o       (sel_o),
   .holdover_o  (holdover_o)
);

// File: tb/test_refclk_guard.sv
`timescale 1ns/1ps
module test_refclk_guard;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ref_clk = 2'b00;
   logic [1:0] ref_en = 2'b11;
   logic       revert = 1'b0;
   logic [1:0] mask = 2'b00;
   logic [1:0] clr = 2'b00;
   logic       sel, hold, irq;
   logic [1:0] sts;

   int total = 0, fails = 0;
   bit done = 1'b0;
   bit run0 = 1'b1, run1 = 1'b1;
   int half0 = 10, half1 = 10;
   int c0 = 0, c1 = 0;

   always #2 clk = ~clk;

   refclk_guard i_refclk_guard (
      .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .ref_en_i(ref_en),
      .revert_en_i(revert), .fail_mask_i(mask), .fail_clr_i(clr),
      .sel_o(sel), .holdover_o(hold), .fail_sts_o(sts), .irq_o(irq)
   );

   initial forever begin
      @(negedge clk);
      if (!run0) begin ref_clk[0] = 1'b0; c0 = 0; end
      else if (c0 >= half0 - 1) begin ref_clk[0] = ~ref_clk[0]; c0 = 0; end
      else c0++;
      if (!run1) begin ref_clk[1] = 1'b0; c1 = 0; end
      else if (c1 >= half1 - 1) begin ref_clk[1] = ~ref_clk[1]; c1 = 0; end
      else c1++;
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      run0 = 1'b1; run1 = 1'b1; half0 = 10; half1 = 10;
      ref_en = 2'b11; revert = 1'b0; mask = 2'b00; clr = 2'b00;
      cyc(5);
      rst_n = 1'b1;
      cyc(20);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 sel", sel, 0);
      chk("R1 holdover", hold, 0);
      chk("R1 status", sts, 0);
      chk("R1 irq", irq, 0);
   endtask

   task automatic t_gap();
      do_reset();
      half0 = 31;
      cyc(600);
      chk("R2 62-cycle period stays healthy", sts, 0);
      chk("R2 primary kept", sel, 0);
      half0 = 35;
      cyc(300);
      chk("R2 70-cycle period is lost", sts, 1);
   endtask

   task automatic t_norevert();
      do_reset();
      run0 = 1'b0;
      cyc(150);
      chk("R3 primary status", sts, 1);
      chk("R4 irq unmasked", irq, 1);
      chk("R6 switched to backup", sel, 1);
      chk("R6 no holdover", hold, 0);
      run0 = 1'b1;
      cyc(500);
      chk("R8 selection stays on backup", sel, 1);
      chk("R8 status sticky", sts, 1);
      clr = 2'b01;
      cyc(1);
      clr = 2'b00;
      cyc(3);
      chk("R8 clear pulse", sts, 0);
      chk("R8 irq after clear", irq, 0);
   endtask

   task automatic t_mask();
      do_reset();
      mask = 2'b01;
      run0 = 1'b0;
      cyc(150);
      chk("R4 masked status set", sts, 1);
      chk("R4 masked irq low", irq, 0);
      mask = 2'b10;
      cyc(2);
      chk("R4 other mask irq high", irq, 1);
   endtask

   task automatic t_holdover();
      do_reset();
      run0 = 1'b0; run1 = 1'b0;
      cyc(200);
      chk("R7 holdover entered", hold, 1);
      chk("R3 both status", sts, 3);
      run1 = 1'b1;
      cyc(400);
      chk("R7 holdover left", hold, 0);
      chk("R7 backup chosen", sel, 1);
      do_reset();
      run0 = 1'b0; run1 = 1'b0;
      cyc(200);
      chk("R7 holdover again", hold, 1);
      run0 = 1'b1; run1 = 1'b1;
      cyc(400);
      chk("R7 exit holdover both", hold, 0);
      chk("R7 primary preferred", sel, 0);
   endtask

   task automatic t_revert();
      do_reset();
      revert = 1'b1;
      run0 = 1'b0;
      cyc(150);
      chk("R9 on backup", sel, 1);
      chk("R9 status set", sts, 1);
      run0 = 1'b1;
      cyc(200);
      chk("R5 not yet recovered status", sts, 1);
      chk("R5 not yet recovered sel", sel, 1);
      cyc(150);
      chk("R9 status cleared", sts, 0);
      chk("R9 irq cleared", irq, 0);
      chk("R9 back to primary", sel, 0);
   endtask

   task automatic t_disabled();
      do_reset();
      ref_en = 2'b01;
      run1 = 1'b0;
      cyc(200);
      chk("R10 disabled no status", sts, 0);
      chk("R10 disabled no irq", irq, 0);
      chk("R10 primary kept", sel, 0);
      run0 = 1'b0;
      cyc(150);
      chk("R10 disabled backup not eligible", hold, 1);
      chk("R10 only primary flagged", sts, 1);
   endtask

   initial begin
      t_reset();
      t_gap();
      t_norevert();
      t_mask();
      t_holdover();
      t_revert();
      t_disabled();
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #600000;
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule